// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Fall-Through Output

This block is a first-in first-out buffer between two clock domains. Words enter on the write port at rising edges of `wclk` and leave on the read port at rising edges of `rclk`. The two clocks may be unrelated, or they may be the very same clock. Pointers cross between the domains as Gray code through a chain of synchronizer flops. As a result, each flag is conservative: it can clear late, but it never clears early.

An output mode is captured while the full reset `rst_all` is held. In standard mode a stored word stays in memory until a read asks for it. `rd_flag` then reports empty and `wr_flag` reports full. In fall-through mode the oldest word is placed on `rd_data` without any request. `rd_flag` then reports that valid data is present, and `wr_flag` reports that space is free. A second reset, `rst_flush`, discards every stored word but keeps the captured mode.

Both resets are synchronous and active high. Each must be held for at least three cycles of the slower clock so that both domains see it.

Top module: `dcfifo_ft`

## Requirements
- R1: A word is stored only at a `wclk` rising edge with `wr_en` high and room available. Words leave in the order written, with none lost or repeated, whether the clocks are unrelated or identical.
- R2: In standard mode (`ft_mode` = 0 at reset), a word written into an empty buffer does not appear on `rd_data` until it is read. After an rclk edge that samples `rd_en` = 1 with `rd_flag` = 0, the word is on `rd_data`. It stays there until the next read.
- R3: In standard mode, `rd_flag` = 1 means empty and `wr_flag` = 1 means full. `wr_flag` rises after exactly DEPTH writes with no reads.
- R4: In fall-through mode (`ft_mode` = 1 at reset), the oldest word appears on `rd_data` with `rd_flag` = 1 and no read. It is held until an rclk edge samples `rd_en` = 1. After that edge the next word is shown, or `rd_flag` drops to 0.
- R5: In fall-through mode, `wr_flag` = 1 means room is available. The buffer accepts DEPTH+1 words (DEPTH in memory and one on the output) before `wr_flag` falls to 0.
- R6: A write while full is dropped. It leaves the stored words and all later output unchanged.
- R7: A read while empty (standard mode) or while `rd_flag` = 0 (fall-through mode) is ignored. No word is skipped afterwards.
- R8: The mode is captured from `ft_mode` while `rst_all` is high. Later changes of `ft_mode` have no effect.
- R9: `rst_flush` empties the buffer and keeps the captured mode. In fall-through mode, `rd_flag` = 0 and `wr_flag` = 1 afterwards.
- R10: After `rst_all`, `rd_data` is 0 and the buffer is empty and not full.
- R11: The flags never overstate. `rd_flag` never offers a word that has not been written, and `wr_flag` never offers space that is occupied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-port clock |
| rclk | input | 1 | Read-port clock |
| rst_all | input | 1 | Full reset: clears pointers and captures the mode |
| rst_flush | input | 1 | Flush reset: clears pointers and keeps the mode |
| ft_mode | input | 1 | Mode select sampled during rst_all (1 = fall-through) |
| wr_en | input | 1 | Write request, wclk domain |
| wr_data | input | DATA_W | Write data |
| wr_flag | output | 1 | Full (standard) or room available (fall-through), wclk domain |
| rd_en | input | 1 | Read request, rclk domain |
| rd_data | output | DATA_W | Read data |
| rd_flag | output | 1 | Empty (standard) or data valid (fall-through), rclk domain |

## Verification
Long random runs mix bursts and idle gaps on both ports. They are run once with unrelated clock periods and once with a single shared clock. This separates synchronizer-delay faults from plain pointer faults, and each run is checked against a queue model for order and for flag honesty.

Directed sequences check the mode-specific cases:
- A lone word that must or must not appear without a read.
- Fills to the exact capacity of each mode.
- Writes into a full buffer and reads from an empty one.
- A mode-input change after reset.
- A flush with data still stored.

Each of these tells the two output modes apart.

// File: rtl/dcfifo_pkg.sv
package dcfifo_pkg;
  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_FALL = 1'b1
  } out_mode_e;
endpackage

// File: rtl/dcfifo_sync.sv
// Multi-flop synchronizer for a Gray-coded pointer.
module dcfifo_sync #(
  parameter int WIDTH  = 5,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stage;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage <= '0;
    end else begin
      stage[0] <= d;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/dcfifo_ram.sv
// Simple dual-port memory: write on wclk, registered read on rclk.
module dcfifo_ram #(
  parameter int DATA_W = 36,
  parameter int AW     = 4
) (
  input  logic              wclk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rclk,
  input  logic              rrst,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] q
);
  localparam int WORDS = 1 << AW;
  logic [DATA_W-1:0] mem [WORDS];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (rrst)    q <= '0;
    else if (re) q <= mem[raddr];
  end
endmodule

// File: rtl/dcfifo_wr.sv
// Write-domain pointer, full detection and write-side flag.
module dcfifo_wr
  import dcfifo_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic        clk,
  input  logic        rst_all,
  input  logic        rst_flush,
  input  logic        ft_mode,
  input  logic        wr_en,
  input  logic [AW:0] rptr_gray_s,
  output logic [AW:0] wptr_gray,
  output logic [AW-1:0] waddr,
  output logic        ram_we,
  output logic        flag
);
  out_mode_e   mode_q;
  logic [AW:0] wbin, wgray, wbin_nx, wgray_nx;
  logic        full_r, full_nx, push;

  assign push     = wr_en & ~full_r;
  assign wbin_nx  = wbin + {{AW{1'b0}}, push};
  assign wgray_nx = wbin_nx ^ (wbin_nx >> 1);
  assign full_nx  = (wgray_nx == {~rptr_gray_s[AW:AW-1], rptr_gray_s[AW-2:0]});

  always_ff @(posedge clk) begin
    if (rst_all) mode_q <= out_mode_e'(ft_mode);
  end

  always_ff @(posedge clk) begin
    if (rst_all || rst_flush) begin
      wbin   <= '0;
      wgray  <= '0;
      full_r <= 1'b0;
      flag   <= rst_all ? ft_mode : (mode_q == MODE_FALL);
    end else begin
      wbin   <= wbin_nx;
      wgray  <= wgray_nx;
      full_r <= full_nx;
      flag   <= (mode_q == MODE_FALL) ? ~full_nx : full_nx;
    end
  end

  assign wptr_gray = wgray;
  assign waddr     = wbin[AW-1:0];
  assign ram_we    = push;

  // R6: a write request while full must not move the pointer
  a_r6_drop_when_full: assert property (@(posedge clk) disable iff (rst_all || rst_flush)
    (full_r && wr_en) |=> $stable(wbin));

  // R1: the Gray pointer changes by at most one bit per edge
  a_r1_wgray_step: assert property (@(posedge clk) disable iff (rst_all || rst_flush)
    $countones(wgray ^ $past(wgray)) <= 1);
endmodule

// File: rtl/dcfifo_rd.sv
// Read-domain pointer, empty detection, fall-through fetch and read-side flag.
module dcfifo_rd
  import dcfifo_pkg::*;
#(
  parameter int AW     = 4,
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst_all,
  input  logic              rst_flush,
  input  logic              ft_mode,
  input  logic              rd_en,
  input  logic [AW:0]       wptr_gray_s,
  input  logic [DATA_W-1:0] out_data,
  output logic [AW:0]       rptr_gray,
  output logic [AW-1:0]     raddr,
  output logic              ram_re,
  output logic              flag
);
  out_mode_e   mode_q;
  logic [AW:0] rbin, rgray, rbin_nx, rgray_nx;
  logic        empty_r, empty_nx, shown, shown_nx, fetch;

  always_comb begin
    if (mode_q == MODE_FALL) fetch = ~empty_r & (~shown | rd_en);
    else                     fetch = rd_en & ~empty_r;
  end

  assign rbin_nx  = rbin + {{AW{1'b0}}, fetch};
  assign rgray_nx = rbin_nx ^ (rbin_nx >> 1);
  assign empty_nx = (rgray_nx == wptr_gray_s);
  assign shown_nx = fetch ? 1'b1 : (rd_en ? 1'b0 : shown);

  always_ff @(posedge clk) begin
    if (rst_all) mode_q <= out_mode_e'(ft_mode);
  end

  always_ff @(posedge clk) begin
    if (rst_all || rst_flush) begin
      rbin    <= '0;
      rgray   <= '0;
      empty_r <= 1'b1;
      shown   <= 1'b0;
      flag    <= rst_all ? ~ft_mode : (mode_q == MODE_STD);
    end else begin
      rbin    <= rbin_nx;
      rgray   <= rgray_nx;
      empty_r <= empty_nx;
      shown   <= shown_nx;
      flag    <= (mode_q == MODE_FALL) ? shown_nx : empty_nx;
    end
  end

  assign rptr_gray = rgray;
  assign raddr     = rbin[AW-1:0];
  assign ram_re    = fetch;

  // R7: nothing is taken from memory while it holds no unread word
  a_r7_ignore_empty_read: assert property (@(posedge clk) disable iff (rst_all || rst_flush)
    empty_r |=> $stable(rbin));

  // R4: a shown word stays put until a read takes it
  a_r4_hold_output: assert property (@(posedge clk) disable iff (rst_all || rst_flush)
    (mode_q == MODE_FALL && flag && !rd_en) |=> (flag && $stable(out_data)));

  // R1: the Gray pointer changes by at most one bit per edge
  a_r1_rgray_step: assert property (@(posedge clk) disable iff (rst_all || rst_flush)
    $countones(rgray ^ $past(rgray)) <= 1);
endmodule

// File: rtl/dcfifo_ft.sv
// Dual-clock FIFO, top level.
module dcfifo_ft #(
  parameter int DATA_W      = 36,
  parameter int DEPTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              rst_all,
  input  logic              rst_flush,
  input  logic              ft_mode,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_flag,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_flag
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic [PW-1:0] wgray, rgray, wgray_s, rgray_s;
  logic [AW-1:0] waddr, raddr;
  logic          ram_we, ram_re, any_rst;

  assign any_rst = rst_all | rst_flush;

  dcfifo_sync #(.WIDTH(PW), .STAGES(SYNC_STAGES)) u_sync_r2w (
    .clk(wclk), .rst(any_rst), .d(rgray), .q(rgray_s));

  dcfifo_sync #(.WIDTH(PW), .STAGES(SYNC_STAGES)) u_sync_w2r (
    .clk(rclk), .rst(any_rst), .d(wgray), .q(wgray_s));

  dcfifo_wr #(.AW(AW)) u_wr (
    .clk(wclk), .rst_all(rst_all), .rst_flush(rst_flush), .ft_mode(ft_mode),
    .wr_en(wr_en), .rptr_gray_s(rgray_s), .wptr_gray(wgray), .waddr(waddr),
    .ram_we(ram_we), .flag(wr_flag));

  dcfifo_rd #(.AW(AW), .DATA_W(DATA_W)) u_rd (
    .clk(rclk), .rst_all(rst_all), .rst_flush(rst_flush), .ft_mode(ft_mode),
    .rd_en(rd_en), .wptr_gray_s(wgray_s), .out_data(rd_data), .rptr_gray(rgray),
    .raddr(raddr), .ram_re(ram_re), .flag(rd_flag));

  dcfifo_ram #(.DATA_W(DATA_W), .AW(AW)) u_ram (
    .wclk(wclk), .we(ram_we), .waddr(waddr), .wdata(wr_data),
    .rclk(rclk), .rrst(any_rst), .re(ram_re), .raddr(raddr), .q(rd_data));
endmodule

// File: tb/tb_dcfifo_ft.sv
`timescale 1ns/1ps
module tb_dcfifo_ft;
  localparam int W = 36;
  localparam int DEPTH = 16;

  logic wclk = 1'b0, rclk_free = 1'b0, same_clk = 1'b0;
  logic rclk;
  logic rst_all = 1'b1, rst_flush = 1'b0, ft_mode = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] rd_data;
  logic wr_flag, rd_flag;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [W-1:0] q[$];

  always #10 wclk = ~wclk;
  always #17 rclk_free = ~rclk_free;
  assign rclk = same_clk ? wclk : rclk_free;

  dcfifo_ft #(.DATA_W(W), .DEPTH(DEPTH)) dut (
    .wclk(wclk), .rclk(rclk), .rst_all(rst_all), .rst_flush(rst_flush),
    .ft_mode(ft_mode), .wr_en(wr_en), .wr_data(wr_data), .wr_flag(wr_flag),
    .rd_en(rd_en), .rd_data(rd_data), .rd_flag(rd_flag));

  task automatic check(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] rnd();
    logic [63:0] r;
    r = {$urandom, $urandom};
    return r[W-1:0];
  endfunction

  task automatic wait_r(input int n); repeat (n) @(negedge rclk); endtask
  task automatic wait_w(input int n); repeat (n) @(negedge wclk); endtask

  task automatic push_word(input logic [W-1:0] d);
    @(negedge wclk); wr_en = 1'b1; wr_data = d;
    @(negedge wclk); wr_en = 1'b0;
  endtask

  task automatic read_once(output logic [W-1:0] d);
    @(negedge rclk); rd_en = 1'b1;
    @(negedge rclk); rd_en = 1'b0; d = rd_data;
  endtask

  task automatic do_reset(input bit mode, input bit same);
    @(negedge wclk);
    rst_all = 1'b1; ft_mode = mode; same_clk = same; wr_en = 1'b0; rd_en = 1'b0;
    wait_w(10);
    rst_all = 1'b0;
    wait_w(3);
    q.delete();
  endtask

  task automatic fall_expect(input logic [W-1:0] e, input string req);
    logic [W-1:0] d;
    int t;
    t = 0;
    @(negedge rclk);
    while (!rd_flag && t < 10) begin @(negedge rclk); t++; end
    check(rd_flag && rd_data == e, req, rd_data, e);
    read_once(d);
  endtask

  task automatic run_random(input bit fall, input int n);
    fork
      begin : writer
        int pushed;
        bit room;
        int r;
        logic [W-1:0] d;
        pushed = 0;
        while (pushed < n) begin
          @(negedge wclk);
          room = fall ? wr_flag : !wr_flag;
          r = $urandom % 4;
          if (room && r != 0) begin
            // R11: room is only offered when space truly exists
            check(q.size() <= (fall ? DEPTH : DEPTH-1), "R11 room", W'(q.size()), W'(fall ? DEPTH : DEPTH-1));
            d = rnd(); wr_en = 1'b1; wr_data = d; q.push_back(d); pushed++;
          end else if (!room && r == 0) begin
            wr_en = 1'b1; wr_data = rnd(); // R6: dropped
          end else begin
            wr_en = 1'b0;
          end
        end
        @(negedge wclk); wr_en = 1'b0;
      end
      begin : reader
        int popped;
        bit pend;
        logic [W-1:0] e;
        popped = 0; pend = 0; e = '0;
        while (popped < n || pend) begin
          @(negedge rclk);
          rd_en = 1'b0;
          if (!fall) begin
            if (pend) begin check(rd_data == e, "R1 order standard", rd_data, e); pend = 0; end
            if (popped < n) begin
              if (!rd_flag && ($urandom % 3 != 0)) begin
                check(q.size() > 0, "R11 data offered", W'(q.size()), W'(1));
                if (q.size() > 0) e = q.pop_front();
                rd_en = 1'b1; pend = 1; popped++;
              end else if (rd_flag && ($urandom % 4 == 0)) begin
                rd_en = 1'b1; // R7: ignored
              end
            end
          end else begin
            if (rd_flag) begin
              check(q.size() > 0, "R11 data offered", W'(q.size()), W'(1));
              if (q.size() > 0) begin
                check(rd_data == q[0], "R1 order fall-through", rd_data, q[0]);
                if ($urandom % 3 != 0) begin void'(q.pop_front()); rd_en = 1'b1; popped++; end
              end
            end else if ($urandom % 4 == 0) begin
              rd_en = 1'b1; // R7: ignored
            end
          end
        end
        @(negedge rclk); rd_en = 1'b0;
      end
    join
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge wclk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      finish_run();
    end
  end

  initial begin : main
    logic [W-1:0] a, b, c, d;
    int cnt;
    void'($urandom(32'd1234));

    // ---- standard mode, unrelated clocks ----
    do_reset(1'b0, 1'b0);
    @(negedge rclk);
    check(rd_data == '0, "R10 data cleared", rd_data, '0);
    check(rd_flag == 1'b1, "R10 empty", W'(rd_flag), W'(1));
    check(wr_flag == 1'b0, "R10 not full", W'(wr_flag), W'(0));

    a = rnd();
    push_word(a);
    wait_r(12);
    check(rd_flag == 1'b0, "R3 not empty", W'(rd_flag), W'(0));
    check(rd_data == '0, "R2 not shown before read", rd_data, '0);
    read_once(d);
    check(d == a, "R2 shown after read", d, a);
    wait_r(5);
    check(rd_data == a, "R2 held", rd_data, a);
    check(rd_flag == 1'b1, "R3 empty again", W'(rd_flag), W'(1));

    @(negedge rclk); rd_en = 1'b1;
    wait_r(5); rd_en = 1'b0;
    b = rnd(); c = rnd();
    push_word(b); push_word(c);
    wait_r(12);
    read_once(d); check(d == b, "R7 first after empty reads", d, b);
    read_once(d); check(d == c, "R7 second after empty reads", d, c);

    for (int i = 0; i < DEPTH; i++) begin
      if (i == DEPTH-1) check(wr_flag == 1'b0, "R3 not full before last", W'(wr_flag), W'(0));
      a = rnd(); q.push_back(a); push_word(a);
    end
    check(wr_flag == 1'b1, "R3 full after DEPTH", W'(wr_flag), W'(1));
    push_word(rnd());
    check(wr_flag == 1'b1, "R6 still full", W'(wr_flag), W'(1));
    wait_r(6);
    for (int i = 0; i < DEPTH; i++) begin
      a = q.pop_front();
      read_once(d);
      check(d == a, "R6 stored words intact", d, a);
    end
    wait_r(2);
    check(rd_flag == 1'b1, "R6 no extra word", W'(rd_flag), W'(1));

    run_random(1'b0, 400);

    // ---- fall-through mode, unrelated clocks ----
    do_reset(1'b1, 1'b0);
    @(negedge rclk);
    check(rd_data == '0, "R10 data cleared", rd_data, '0);
    check(rd_flag == 1'b0, "R10 nothing ready", W'(rd_flag), W'(0));
    check(wr_flag == 1'b1, "R10 room", W'(wr_flag), W'(1));

    a = rnd(); b = rnd();
    push_word(a);
    wait_r(12);
    check(rd_flag == 1'b1 && rd_data == a, "R4 appears without read", rd_data, a);
    push_word(b);
    wait_r(8);
    check(rd_data == a, "R4 held until read", rd_data, a);
    read_once(d);
    check(rd_flag == 1'b1 && rd_data == b, "R4 next word after read", rd_data, b);
    read_once(d);
    check(rd_flag == 1'b0, "R4 not ready after last", W'(rd_flag), W'(0));

    @(negedge rclk); rd_en = 1'b1;
    wait_r(5); rd_en = 1'b0;
    c = rnd();
    push_word(c);
    wait_r(12);
    check(rd_flag == 1'b1 && rd_data == c, "R7 ignored reads", rd_data, c);
    read_once(d);

    ft_mode = 1'b0;
    a = rnd();
    push_word(a);
    wait_r(12);
    check(rd_flag == 1'b1 && rd_data == a, "R8 mode kept", rd_data, a);
    read_once(d);
    wait_r(4);

    cnt = 0;
    @(negedge wclk);
    while (wr_flag == 1'b1 && cnt < DEPTH + 4) begin
      a = rnd(); q.push_back(a); push_word(a); wait_w(8); cnt++;
    end
    check(cnt == DEPTH + 1, "R5 capacity", W'(cnt), W'(DEPTH + 1));
    check(wr_flag == 1'b0, "R5 no room", W'(wr_flag), W'(0));
    push_word(rnd());
    for (int i = 0; i < DEPTH + 1; i++) begin
      a = q.pop_front();
      fall_expect(a, "R6 drain after full write");
    end
    wait_r(10);
    check(rd_flag == 1'b0, "R6 no extra word", W'(rd_flag), W'(0));

    for (int i = 0; i < 3; i++) push_word(rnd());
    wait_r(10);
    @(negedge wclk); rst_flush = 1'b1;
    wait_w(10); rst_flush = 1'b0;
    wait_w(3);
    @(negedge rclk);
    check(rd_flag == 1'b0, "R9 flushed", W'(rd_flag), W'(0));
    check(wr_flag == 1'b1, "R9 room", W'(wr_flag), W'(1));
    a = rnd();
    push_word(a);
    wait_r(12);
    check(rd_flag == 1'b1 && rd_data == a, "R9 mode retained", rd_data, a);
    read_once(d);
    q.delete();

    run_random(1'b1, 400);

    // ---- identical clocks ----
    do_reset(1'b1, 1'b1);
    run_random(1'b1, 300);
    do_reset(1'b0, 1'b1);
    run_random(1'b0, 300);

    finish_run();
  end
endmodule